// File: doc/BRIEF.md
# LIN Response Data-Length Counter

This block holds the two 4-bit response length fields of a LIN 2.1 frame engine, one for transmit and one for receive. When the engine issues a transmit or receive response command, the block stores the commanded length in the matching field. A length above 8 is cut to 8 before any byte is handled. The block then tells the byte engine how many data bytes remain and when the next byte is the checksum.

While a response runs, the block reuses the opposite field as a progress counter. A transmit response counts into the receive field, and a receive response counts into the transmit field. The counter counts bytes that completed with no error. On the first error the response stops and the counter keeps its value, so firmware can read how far the frame got.

A length of 0 means a checksum-only response. On transmit, only the checksum byte is sent. On receive, the first byte is taken as the checksum.

Top module: `lin_resp_len_ctrl`

## Requirements
- R1: After reset, `tx_len_o` and `rx_len_o` are 0, and `busy_o`, `csum_next_o` and `resp_done_o` are low. `bytes_left_o` is 0.
- R2: On the clock edge where a command is accepted, the commanded field takes the smaller of `cmd_len_i` and 8. The commanded field is `tx_len_o` for `cmd_tx_i` and `rx_len_o` for `cmd_rx_i`. Lengths 9 to 15 therefore read as 8.
- R3: The same edge also does two more things. It clears the opposite field, which becomes the progress count, to 0. It sets `busy_o`.
- R4: A `byte_done_i` with `byte_err_i` low, taken while busy and while the count is below the length, adds 1 to the progress field. While busy, `bytes_left_o` equals the length minus the count. When not busy, `bytes_left_o` is 0.
- R5: `csum_next_o` is high exactly when the block is busy and the count equals the length. With length 0, this is true from the cycle after the command.
- R6: An error-free `byte_done_i` taken while `csum_next_o` is high ends the response. On the next cycle `resp_done_o` is high for one cycle and `busy_o` is low. The progress field keeps its value.
- R7: A `byte_done_i` with `byte_err_i` high, taken while busy, stops the response. `busy_o` goes low, the progress field keeps the count from before the error, and no `resp_done_o` pulse follows.
- R8: `byte_done_i` while not busy has no effect on any output.
- R9: If `cmd_tx_i` and `cmd_rx_i` are both high in one cycle, the transmit command wins. A command taken while busy restarts the response with the new length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_tx_i | input | 1 | Transmit response command pulse |
| cmd_rx_i | input | 1 | Receive response command pulse |
| cmd_len_i | input | 4 | Commanded data length, sampled with a command |
| byte_done_i | input | 1 | Strobe: one byte (data or checksum) finished |
| byte_err_i | input | 1 | Qualifies `byte_done_i`: that byte had an error |
| tx_len_o | output | 4 | Transmit length field, or progress count during a receive response |
| rx_len_o | output | 4 | Receive length field, or progress count during a transmit response |
| bytes_left_o | output | 4 | Data bytes still to go before the checksum |
| csum_next_o | output | 1 | The next byte is the checksum |
| busy_o | output | 1 | A response is in progress |
| resp_done_o | output | 1 | One-cycle pulse after the checksum byte is done |

## Verification
Every registered result is due on the clock edge that samples its stimulus. This covers a field load, a count step, the end of a response and the `resp_done_o` pulse. `csum_next_o` and `bytes_left_o` are decoded from those registers in the same cycle. The bench changes inputs on the falling edge, and holds a command or strobe for exactly one rising edge. It reads outputs on the next falling edge, which is one rising edge after the stimulus. It checks that `resp_done_o` has dropped one falling edge later again.

// File: rtl/lin_len_pkg.sv
package lin_len_pkg;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } resp_dir_e;

endpackage

// File: rtl/lin_len_clamp.sv
module lin_len_clamp #(
    parameter int LEN_W   = 4,
    parameter int MAX_LEN = 8
) (
    input  logic [LEN_W-1:0] raw_i,
    output logic [LEN_W-1:0] len_o
);
    localparam logic [LEN_W-1:0] LIMIT = LEN_W'(MAX_LEN);

    always_comb begin
        len_o = (raw_i > LIMIT) ? LIMIT : raw_i;
    end

    always_comb begin
        assert_clamp_bound_R2: assert (len_o <= LIMIT);
    end
endmodule

// File: rtl/lin_len_seq.sv
module lin_len_seq
    import lin_len_pkg::*;
#(
    parameter int LEN_W   = 4,
    parameter int MAX_LEN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_tx_i,
    input  logic             cmd_rx_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic             byte_done_i,
    input  logic             byte_err_i,
    output logic             busy_o,
    output resp_dir_e        dir_o,
    output logic [LEN_W-1:0] len_o,
    output logic [LEN_W-1:0] cnt_o,
    output logic             done_o
);
    typedef struct packed {
        logic             busy;
        resp_dir_e        dir;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] cnt;
        logic             done;
    } seq_state_t;

    seq_state_t state_d, state_q;
    logic       cmd_any;

    assign cmd_any = cmd_tx_i | cmd_rx_i;

    always_comb begin
        state_d      = state_q;
        state_d.done = 1'b0;
        if (cmd_any) begin
            state_d.busy = 1'b1;
            state_d.dir  = cmd_tx_i ? DIR_TX : DIR_RX;
            state_d.len  = len_i;
            state_d.cnt  = '0;
        end else if (byte_done_i && state_q.busy) begin
            if (byte_err_i) begin
                state_d.busy = 1'b0;
            end else if (state_q.cnt == state_q.len) begin
                state_d.busy = 1'b0;
                state_d.done = 1'b1;
            end else begin
                state_d.cnt = state_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '{busy: 1'b0, dir: DIR_TX, len: '0, cnt: '0, done: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign busy_o = state_q.busy;
    assign dir_o  = state_q.dir;
    assign len_o  = state_q.len;
    assign cnt_o  = state_q.cnt;
    assign done_o = state_q.done;

    assert_cnt_within_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.busy |-> (state_q.cnt <= state_q.len));

    assert_cmd_clears_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_any |=> (state_q.busy && state_q.cnt == '0));

    assert_tx_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_tx_i && cmd_rx_i) |=> (state_q.dir == DIR_TX));

    assert_done_one_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state_q.done |=> !state_q.done);

    assert_error_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q.busy && byte_done_i && byte_err_i && !cmd_any)
        |=> (!state_q.busy && !state_q.done && $stable(state_q.cnt)));

    assert_idle_ignores_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!state_q.busy && !cmd_any)
        |=> ($stable(state_q.cnt) && $stable(state_q.len) && !state_q.done && !state_q.busy));
endmodule

// File: rtl/lin_len_view.sv
module lin_len_view
    import lin_len_pkg::*;
#(
    parameter int LEN_W = 4
) (
    input  logic             busy_i,
    input  resp_dir_e        dir_i,
    input  logic [LEN_W-1:0] len_i,
    input  logic [LEN_W-1:0] cnt_i,
    output logic [LEN_W-1:0] tx_field_o,
    output logic [LEN_W-1:0] rx_field_o,
    output logic [LEN_W-1:0] left_o,
    output logic             csum_next_o
);
    always_comb begin
        if (dir_i == DIR_TX) begin
            tx_field_o = len_i;
            rx_field_o = cnt_i;
        end else begin
            tx_field_o = cnt_i;
            rx_field_o = len_i;
        end
        left_o      = busy_i ? (len_i - cnt_i) : '0;
        csum_next_o = busy_i && (cnt_i == len_i);
    end

    always_comb begin
        assert_csum_no_left_R5: assert (!csum_next_o || left_o == '0);
    end
endmodule

// File: rtl/lin_resp_len_ctrl.sv
module lin_resp_len_ctrl
    import lin_len_pkg::*;
#(
    parameter int LEN_W   = 4,
    parameter int MAX_LEN = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_tx_i,
    input  logic             cmd_rx_i,
    input  logic [LEN_W-1:0] cmd_len_i,
    input  logic             byte_done_i,
    input  logic             byte_err_i,
    output logic [LEN_W-1:0] tx_len_o,
    output logic [LEN_W-1:0] rx_len_o,
    output logic [LEN_W-1:0] bytes_left_o,
    output logic             csum_next_o,
    output logic             busy_o,
    output logic             resp_done_o
);
    logic [LEN_W-1:0] len_clamped;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] cnt_q;
    resp_dir_e        dir_q;

    lin_len_clamp #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_clamp (
        .raw_i (cmd_len_i),
        .len_o (len_clamped)
    );

    lin_len_seq #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_tx_i    (cmd_tx_i),
        .cmd_rx_i    (cmd_rx_i),
        .len_i       (len_clamped),
        .byte_done_i (byte_done_i),
        .byte_err_i  (byte_err_i),
        .busy_o      (busy_o),
        .dir_o       (dir_q),
        .len_o       (len_q),
        .cnt_o       (cnt_q),
        .done_o      (resp_done_o)
    );

    lin_len_view #(.LEN_W(LEN_W)) u_view (
        .busy_i      (busy_o),
        .dir_i       (dir_q),
        .len_i       (len_q),
        .cnt_i       (cnt_q),
        .tx_field_o  (tx_len_o),
        .rx_field_o  (rx_len_o),
        .left_o      (bytes_left_o),
        .csum_next_o (csum_next_o)
    );
endmodule

// File: tb/lin_resp_len_ctrl_tb_top.sv
module lin_resp_len_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic       is_tx;
        logic [3:0] len;
        logic [3:0] exp_len;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        '{1'b1, 4'd0,  4'd0}, '{1'b0, 4'd0,  4'd0},
        '{1'b1, 4'd1,  4'd1}, '{1'b0, 4'd1,  4'd1},
        '{1'b1, 4'd8,  4'd8}, '{1'b0, 4'd8,  4'd8},
        '{1'b1, 4'd9,  4'd8}, '{1'b0, 4'd9,  4'd8},
        '{1'b1, 4'd15, 4'd8}, '{1'b0, 4'd15, 4'd8}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_tx = 1'b0, cmd_rx = 1'b0;
    logic [3:0] cmd_len = '0;
    logic       byte_done = 1'b0, byte_err = 1'b0;
    logic [3:0] tx_len, rx_len, bytes_left;
    logic       csum_next, busy, resp_done;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    lin_resp_len_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_tx_i     (cmd_tx),
        .cmd_rx_i     (cmd_rx),
        .cmd_len_i    (cmd_len),
        .byte_done_i  (byte_done),
        .byte_err_i   (byte_err),
        .tx_len_o     (tx_len),
        .rx_len_o     (rx_len),
        .bytes_left_o (bytes_left),
        .csum_next_o  (csum_next),
        .busy_o       (busy),
        .resp_done_o  (resp_done)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic issue(input logic tx, input logic rx, input logic [3:0] len);
        cmd_tx = tx; cmd_rx = rx; cmd_len = len;
        @(negedge clk);
        cmd_tx = 1'b0; cmd_rx = 1'b0; cmd_len = '0;
    endtask

    task automatic strobe(input logic err);
        byte_done = 1'b1; byte_err = err;
        @(negedge clk);
        byte_done = 1'b0; byte_err = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    function automatic int prog(input logic is_tx);
        return is_tx ? int'(rx_len) : int'(tx_len);
    endfunction

    function automatic int field(input logic is_tx);
        return is_tx ? int'(tx_len) : int'(rx_len);
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle();
        // R1 reset state
        chk("R1 tx_len", tx_len, 0);
        chk("R1 rx_len", rx_len, 0);
        chk("R1 busy", busy, 0);
        chk("R1 csum_next", csum_next, 0);
        chk("R1 resp_done", resp_done, 0);
        chk("R1 bytes_left", bytes_left, 0);

        // Table walk: lengths 0, 1, 8, 9, 15 both directions
        for (int v = 0; v < NVEC; v++) begin
            issue(VECS[v].is_tx, ~VECS[v].is_tx, VECS[v].len);
            chk("R2 clamped field", field(VECS[v].is_tx), VECS[v].exp_len);
            chk("R3 progress cleared", prog(VECS[v].is_tx), 0);
            chk("R3 busy set", busy, 1);
            for (int b = 0; b < int'(VECS[v].exp_len); b++) begin
                chk("R4 bytes_left", bytes_left, int'(VECS[v].exp_len) - b);
                chk("R5 csum_next low", csum_next, 0);
                strobe(1'b0);
                chk("R4 progress step", prog(VECS[v].is_tx), b + 1);
            end
            chk("R5 csum_next high", csum_next, 1);
            chk("R5 bytes_left zero", bytes_left, 0);
            strobe(1'b0);
            chk("R6 resp_done pulse", resp_done, 1);
            chk("R6 busy low", busy, 0);
            chk("R6 progress kept", prog(VECS[v].is_tx), VECS[v].exp_len);
            idle();
            chk("R6 resp_done drops", resp_done, 0);
        end

        // R7 error mid-response (rx, length 5)
        issue(1'b0, 1'b1, 4'd5);
        strobe(1'b0);
        strobe(1'b0);
        chk("R7 count before error", tx_len, 2);
        strobe(1'b1);
        chk("R7 busy low after error", busy, 0);
        chk("R7 count held", tx_len, 2);
        chk("R7 length kept", rx_len, 5);
        chk("R7 no resp_done", resp_done, 0);
        idle();
        chk("R7 no late resp_done", resp_done, 0);

        // R8 strobes while idle ignored
        strobe(1'b0);
        chk("R8 tx_len unchanged", tx_len, 2);
        chk("R8 rx_len unchanged", rx_len, 5);
        chk("R8 no resp_done", resp_done, 0);
        chk("R8 busy stays low", busy, 0);
        strobe(1'b1);
        chk("R8 tx_len unchanged after err strobe", tx_len, 2);

        // R9 both commands: transmit wins
        issue(1'b1, 1'b1, 4'd3);
        chk("R9 tx field", tx_len, 3);
        chk("R9 rx progress", rx_len, 0);
        chk("R9 bytes_left", bytes_left, 3);

        // R9 restart while busy
        strobe(1'b0);
        strobe(1'b0);
        chk("R9 progress before restart", rx_len, 2);
        issue(1'b0, 1'b1, 4'd12);
        chk("R9 restart rx field", rx_len, 8);
        chk("R9 restart progress", tx_len, 0);
        chk("R9 restart busy", busy, 1);
        chk("R9 restart bytes_left", bytes_left, 8);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule